// File: doc/BRIEF.md
# Fractional UART Baud Rate Generator

This block turns a free-running input clock into the two timing strobes a UART needs: a one-cycle oversample strobe at sixteen times the bit rate, and a one-cycle bit strobe on every sixteenth oversample strobe. The divide ratio is programmable as an integer part plus a fractional part in sixty-fourths. The average oversample period is therefore `int_div + frac_div/64` input cycles, even though each individual period is a whole number of cycles.

A 6-bit accumulator spreads the fraction. It adds `frac_div` at the start of every oversample period. When that addition carries out, the period is one cycle longer than `int_div`. The divisor inputs are sampled only when a new period begins, so software can reprogram them at run time without producing a short or broken period. This is needed after the source clock frequency changes and the bit rate has to be restored. An integer divisor of zero stops the generator.

Top module: `uart_frac_baud_gen`

## Requirements
- R1: `os_tick` is high for one cycle at the end of each oversample period. Counting periods k = 1, 2, ... from the cycle `en` is sampled high with `int_div` not zero, period k lasts `int_div + 1` cycles when floor(k·frac_div/64) > floor((k-1)·frac_div/64), and `int_div` cycles otherwise. Periods k ≥ 2 are measured as the spacing between consecutive `os_tick` pulses.
- R2: With constant divisors, any 64 consecutive oversample periods last exactly 64·int_div + frac_div cycles in total.
- R3: `baud_tick` is only ever high together with `os_tick`. It is high on the 16th, 32nd, ... `os_tick` counted from the start of generation.
- R4: A change of `int_div` or `frac_div` during a period has no effect on that period. It completes with its old length, and the new values apply from the next period.
- R5: If `int_div` is 0 at a period boundary, the current period's `os_tick` is the last strobe. No further strobes occur while `int_div` stays 0. A later non-zero value restarts generation from cleared counters, so the first `baud_tick` falls on the 16th new `os_tick`.
- R6: While `en` is low, neither strobe is produced and all counters are cleared. After `en` returns high, the first `baud_tick` falls on the 16th `os_tick`.
- R7: While `rst_n` is low, both strobes are low.
- R8: With `int_div` = 1 and `frac_div` = 43 (a 3,072,000 Hz clock and a 115200 target), 64 periods take 107 cycles. The implied rate is within ±5% of the target.
- R9: With `int_div` = 1 and `frac_div` = 0, `os_tick` is high on every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running input clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| en | input | 1 | Generation enable; low clears all counters |
| int_div | input | 16 | Integer part of the oversample divisor; 0 disables |
| frac_div | input | 6 | Fractional part of the divisor in 1/64 units |
| os_tick | output | 1 | One-cycle 16x oversample strobe |
| baud_tick | output | 1 | One-cycle bit-rate strobe, every 16th oversample strobe |

## Verification
The bench sweeps the integer divisor over 1, 2, 3 and 5 and the fraction over 0, 1, 32, 43 and 63. For each pair it predicts the exact length of every period, so a design that added the fraction at the wrong time, or dropped the carry, would shift a long period or change the 64-period total. Divisor changes are made just after a strobe. A design that reloaded mid-period would cut short the period in progress. Zero divisors and enable drops are applied mid-stream, then generation restarts. A design that did not clear the sixteen-count would place the first bit strobe early. The 3,072,000 Hz / 115200 case is measured over 1024 periods and its deviation is reported.

// File: rtl/ufbg_pkg.sv
package ufbg_pkg;
  localparam int unsigned UFBG_INT_W  = 16;
  localparam int unsigned UFBG_FRAC_W = 6;
  localparam int unsigned UFBG_OSR    = 16;

  typedef enum logic {
    GEN_IDLE = 1'b0,
    GEN_RUN  = 1'b1
  } gen_state_e;
endpackage

// File: rtl/ufbg_frac_acc.sv
module ufbg_frac_acc #(
  parameter int unsigned FRAC_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_i,
  input  logic              clr_i,
  input  logic [FRAC_W-1:0] frac_i,
  output logic              carry_o
);
  logic [FRAC_W-1:0] acc_q;
  logic [FRAC_W-1:0] acc_d;
  logic [FRAC_W:0]   sum;

  always_comb begin
    sum     = {1'b0, acc_q} + {1'b0, frac_i};
    carry_o = sum[FRAC_W];
    if (clr_i) begin
      acc_d = '0;
    end else if (step_i) begin
      acc_d = sum[FRAC_W-1:0];
    end else begin
      acc_d = acc_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else begin
      acc_q <= acc_d;
    end
  end

  // R6: a clear request leaves the accumulator empty
  a_r6_acc_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (acc_q == '0));

  // R1: the remainder only moves when a period starts
  a_r1_acc_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !step_i) |=> $stable(acc_q));
endmodule

// File: rtl/ufbg_period_ctr.sv
module ufbg_period_ctr
  import ufbg_pkg::*;
#(
  parameter int unsigned INT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [INT_W-1:0] int_div_i,
  input  logic             carry_i,
  output logic             step_o,
  output logic             acc_clr_o,
  output logic             run_o,
  output logic             os_tick_o
);
  gen_state_e       state_q, state_d;
  logic [INT_W-1:0] cnt_q, cnt_d;
  logic [INT_W:0]   load_ext;
  logic             boundary;
  logic             start;
  logic             div_zero;

  always_comb begin
    div_zero  = (int_div_i == '0);
    boundary  = (state_q == GEN_RUN) && (cnt_q == '0);
    start     = en_i && !div_zero && ((state_q == GEN_IDLE) || boundary);
    load_ext  = {1'b0, int_div_i} + {{INT_W{1'b0}}, carry_i} - {{INT_W{1'b0}}, 1'b1};

    state_d = state_q;
    cnt_d   = cnt_q;
    if (!en_i) begin
      state_d = GEN_IDLE;
      cnt_d   = '0;
    end else if (start) begin
      state_d = GEN_RUN;
      cnt_d   = load_ext[INT_W-1:0];
    end else if (boundary) begin
      state_d = GEN_IDLE;
      cnt_d   = '0;
    end else if (state_q == GEN_RUN) begin
      cnt_d   = cnt_q - {{(INT_W-1){1'b0}}, 1'b1};
    end else begin
      cnt_d   = '0;
    end

    step_o    = start;
    acc_clr_o = (state_d == GEN_IDLE);
    run_o     = en_i && (state_q == GEN_RUN);
    os_tick_o = en_i && boundary;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= GEN_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  // R4: inside a period the count only steps down, whatever the divisor inputs do
  a_r4_count_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && (state_q == GEN_RUN) && (cnt_q != '0)) |=>
      (cnt_q == $past(cnt_q) - {{(INT_W-1){1'b0}}, 1'b1}));

  // R5: a zero divisor at a boundary stops generation
  a_r5_zero_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && (state_q == GEN_RUN) && (cnt_q == '0) && (int_div_i == '0)) |=>
      !os_tick_o);

  // R6: disable returns the generator to idle
  a_r6_disable_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> ((state_q == GEN_IDLE) && (cnt_q == '0)));
endmodule

// File: rtl/ufbg_os_ctr.sv
module ufbg_os_ctr #(
  parameter int unsigned OSR = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic os_tick_i,
  output logic baud_tick_o
);
  localparam int unsigned CW = (OSR > 1) ? $clog2(OSR) : 1;
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    baud_tick_o = os_tick_i && (cnt_q == LAST);
    if (!run_i) begin
      cnt_d = '0;
    end else if (os_tick_i) begin
      cnt_d = (cnt_q == LAST) ? '0 : cnt_q + {{(CW-1){1'b0}}, 1'b1};
    end else begin
      cnt_d = cnt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  // R3: a bit strobe restarts the sixteen-count
  a_r3_wrap_after_baud: assert property (@(posedge clk) disable iff (!rst_n)
    (baud_tick_o && run_i) |=> (cnt_q == '0));

  // R6: while stopped the sixteen-count is held at zero
  a_r6_os_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (cnt_q == '0));
endmodule

// File: rtl/uart_frac_baud_gen.sv
module uart_frac_baud_gen
  import ufbg_pkg::*;
#(
  parameter int unsigned INT_W  = UFBG_INT_W,
  parameter int unsigned FRAC_W = UFBG_FRAC_W,
  parameter int unsigned OSR    = UFBG_OSR
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [INT_W-1:0]  int_div,
  input  logic [FRAC_W-1:0] frac_div,
  output logic              os_tick,
  output logic              baud_tick
);
  logic step;
  logic acc_clr;
  logic carry;
  logic run;

  ufbg_frac_acc #(.FRAC_W(FRAC_W)) u_acc (
    .clk     (clk),
    .rst_n   (rst_n),
    .step_i  (step),
    .clr_i   (acc_clr),
    .frac_i  (frac_div),
    .carry_o (carry)
  );

  ufbg_period_ctr #(.INT_W(INT_W)) u_period (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_i      (en),
    .int_div_i (int_div),
    .carry_i   (carry),
    .step_o    (step),
    .acc_clr_o (acc_clr),
    .run_o     (run),
    .os_tick_o (os_tick)
  );

  ufbg_os_ctr #(.OSR(OSR)) u_os (
    .clk         (clk),
    .rst_n       (rst_n),
    .run_i       (run),
    .os_tick_i   (os_tick),
    .baud_tick_o (baud_tick)
  );

  // R3: bit strobe never stands alone
  a_r3_baud_in_os: assert property (@(posedge clk) disable iff (!rst_n)
    baud_tick |-> os_tick);

  // R6: one cycle after enable drops, the outputs are silent
  a_r6_silent_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !$past(en)) |-> (!os_tick && !baud_tick));
endmodule

// File: tb/uart_frac_baud_gen_tb.sv
module uart_frac_baud_gen_tb;
  logic        clk;
  logic        rst_n;
  logic        en;
  logic [15:0] int_div;
  logic [5:0]  frac_div;
  logic        os_tick;
  logic        baud_tick;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int n = 0;
  int stray = 0;
  bit timed_out = 0;
  int tt [0:8191];
  bit bb [0:8191];

  uart_frac_baud_gen u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .int_div(int_div),
    .frac_div(frac_div), .os_tick(os_tick), .baud_tick(baud_tick)
  );

  initial clk = 0;
  always #4 clk = ~clk;

  initial begin
    repeat (150000) @(posedge clk);
    timed_out = 1;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (baud_tick && !os_tick) stray++;
      if (os_tick) begin
        if (n < 8192) begin
          tt[n] = cyc;
          bb[n] = baud_tick;
        end
        n++;
      end
      cyc++;
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_ticks(int target);
    while (n < target && !timed_out) @(negedge clk);
  endtask

  task automatic run_cfg(int i, int f);
    int m, bad_len, bad_act, bad_exp, bad_b, ex, ac, win;
    en = 0;
    repeat (2) @(negedge clk);
    int_div = 16'(i);
    frac_div = 6'(f);
    m = n;
    en = 1;
    wait_ticks(m + 66);
    bad_len = 0; bad_act = 0; bad_exp = 0; bad_b = 0;
    for (int k = 2; k <= 65; k++) begin
      ex = i + ((k * f) >> 6) - (((k - 1) * f) >> 6);
      ac = tt[m + k - 1] - tt[m + k - 2];
      if (ac != ex && bad_len == 0) begin bad_len = k; bad_act = ac; bad_exp = ex; end
    end
    chk(bad_len == 0, $sformatf("R1 period length i=%0d f=%0d period %0d", i, f, bad_len), bad_act, bad_exp);
    if (i == 1 && f == 0)
      chk(tt[m + 65] - tt[m + 1] == 64, "R9 strobe every cycle", tt[m + 65] - tt[m + 1], 64);
    win = tt[m + 64] - tt[m];
    chk(win == 64 * i + f, $sformatf("R2 64-period total i=%0d f=%0d", i, f), win, 64 * i + f);
    for (int j = 1; j <= 66; j++)
      if (bb[m + j - 1] != ((j % 16) == 0)) bad_b++;
    chk(bad_b == 0, $sformatf("R3 baud placement i=%0d f=%0d", i, f), bad_b, 0);
  endtask

  initial begin
    int ilist [4] = '{1, 2, 3, 5};
    int flist [5] = '{0, 1, 32, 43, 63};
    int m, c0, bad, cyc_tot;
    real avg, rate, dev;
    rst_n = 0; en = 1; int_div = 16'd1; frac_div = 6'd0;
    bad = 0;
    repeat (5) begin
      @(negedge clk);
      if (os_tick || baud_tick) bad++;
    end
    chk(bad == 0, "R7 outputs low in reset", bad, 0);
    en = 0;
    @(negedge clk);
    rst_n = 1;

    // R6: disabled, non-zero divisor
    int_div = 16'd2;
    m = n;
    repeat (30) @(negedge clk);
    chk(n == m, "R6 no strobes while disabled", n - m, 0);

    foreach (ilist[a]) foreach (flist[b]) run_cfg(ilist[a], flist[b]);

    // R8: 3.072 MHz clock, 115200 target
    en = 0;
    repeat (2) @(negedge clk);
    int_div = 16'd1; frac_div = 6'd43;
    m = n; en = 1;
    wait_ticks(m + 1025);
    cyc_tot = tt[m + 1024] - tt[m];
    chk(tt[m + 64] - tt[m] == 107, "R8 64 periods", tt[m + 64] - tt[m], 107);
    chk(cyc_tot == 1024 * 107 / 64, "R8 1024 periods", cyc_tot, 1712);
    avg = real'(cyc_tot) / 1024.0;
    rate = 3072000.0 / (16.0 * avg);
    dev = (115200.0 - rate) / 115200.0 * 100.0;
    $display("R8 measured divisor %f, rate %f baud, deviation %f%% (limit 5%%)", avg, rate, dev);
    chk(dev < 5.0 && dev > -5.0, "R8 deviation within limit (x1000)", int'(dev * 1000.0), 0);

    // R4: change divisor mid-period
    en = 0;
    repeat (2) @(negedge clk);
    int_div = 16'd3; frac_div = 6'd0; en = 1;
    wait_ticks(n + 3);
    @(negedge clk);
    while (!os_tick && !timed_out) @(negedge clk);
    m = n;
    int_div = 16'd5; frac_div = 6'd10;
    wait_ticks(m + 66);
    chk(tt[m] - tt[m - 1] == 3, "R4 running period keeps old length", tt[m] - tt[m - 1], 3);
    chk(tt[m + 65] - tt[m + 1] == 330, "R4 new divisor 64-period total", tt[m + 65] - tt[m + 1], 330);

    // R5: zero divisor at run time
    en = 0;
    repeat (2) @(negedge clk);
    int_div = 16'd2; frac_div = 6'd0; en = 1;
    wait_ticks(n + 7);
    @(negedge clk);
    while (!os_tick && !timed_out) @(negedge clk);
    m = n;
    int_div = 16'd0;
    repeat (40) @(negedge clk);
    chk(n - m == 1, "R5 only the running period completes", n - m, 1);
    m = n;
    int_div = 16'd3; frac_div = 6'd5;
    wait_ticks(m + 17);
    bad = 0;
    for (int j = 1; j <= 17; j++) if (bb[m + j - 1] != (j == 16)) bad++;
    chk(bad == 0, "R5 restart gives baud on 16th strobe", bad, 0);

    // R6: enable drop mid-stream
    wait_ticks(n + 7);
    m = n;
    en = 0;
    repeat (10) @(negedge clk);
    chk(n == m, "R6 silent after enable drop", n - m, 0);
    m = n;
    en = 1;
    wait_ticks(m + 33);
    bad = 0;
    for (int j = 1; j <= 33; j++) if (bb[m + j - 1] != ((j % 16) == 0)) bad++;
    chk(bad == 0, "R6 re-enable restarts sixteen-count", bad, 0);
    c0 = tt[m + 1] - tt[m];
    chk(c0 == 3, "R1 second period after re-enable", c0, 3);

    chk(stray == 0, "R3 baud without oversample strobe", stray, 0);
    if (timed_out) begin
      checks++; errors++;
      $display("FAIL ALL: watchdog expired, actual %0d expected 0", 1);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule